// File: doc/BRIEF.md
# Mailbox Request Sequencer

This block is the host-side master for one command transaction against a register-mapped command responder. A client presents a command code and six 32-bit arguments with a single-cycle start strobe. The sequencer then drives a simple register bus through a fixed series of accesses. It clears the response register and loads the argument registers. It writes the command register last, because that write launches the command. It then polls the response register until the value read is non-zero, and reads every argument register back.

When the sequence ends, the block raises a one-cycle done pulse. With it come the returned arguments, the raw response word, a classification of that word and an error flag. If the responder never answers within a configurable number of polls, the transaction ends with a timeout flag and a zero status. A start strobe that arrives while a transaction is running has no effect. The bus carries at most one access per cycle, and read data returns on the cycle after the read is issued.

Top module: `mbox_seq`

## Requirements
- R1: After reset, busy_o and done_o are low and no bus access is issued until a start is accepted.
- R2: The first bus access of a transaction is a write of zero to the response register (address RSP_ADDR, default 7), issued on the cycle after the start strobe is accepted.
- R3: On the cycles that follow the clear, the argument registers are written one per cycle in index order 0 to 5. Argument i goes to address ARG_BASE+i (default 1+i), with bits [32*i+31:32*i] of args_i as data.
- R4: The command write (address MSG_ADDR, default 0, data cmd_i) immediately follows the last argument write. No other write follows it within the transaction.
- R5: After the command write, the response register is read, and the data returned on the following cycle is examined. Zero starts another read, so each poll takes two cycles. A non-zero value ends the polling.
- R6: If POLL_MAX reads all return zero, the transaction ends without any argument read-back. It reports timeout_o=1, err_o=1, status_o=0, kind_o=6 and args_o all zero.
- R7: After a non-zero response, argument addresses ARG_BASE+0..5 are read in order on consecutive cycles. args_o returns the data read in the same field positions as args_i. done_o rises two cycles after the last read is issued.
- R8: kind_o classifies the full 32-bit response word: 0x01 gives 0 (success, err_o=0). 0xFF gives 1, 0xFE gives 2, 0xFD gives 3 and 0xFC gives 4. Any other non-zero value gives 5. Every kind other than 0 sets err_o. status_o carries the word read.
- R9: busy_o is high from the cycle after acceptance through the done cycle and low on the cycle after it. done_o is high for exactly one cycle. A start strobe while busy_o is high is ignored. Results stay stable from done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| cmd_i | input | DATA_W | Command code written to the command register |
| args_i | input | N_ARGS*DATA_W | Arguments, argument i at [DATA_W*i +: DATA_W] |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| args_o | output | N_ARGS*DATA_W | Arguments read back after completion |
| status_o | output | DATA_W | Final response word (zero on timeout) |
| kind_o | output | 3 | Response classification code |
| err_o | output | 1 | Anything other than success |
| timeout_o | output | 1 | Polling limit reached |
| bus_req_o | output | 1 | Bus access this cycle |
| bus_we_o | output | 1 | Access is a write |
| bus_addr_o | output | ADDR_W | Register address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_rdata_i | input | DATA_W | Read data, valid the cycle after a read |

## Verification
The bench builds the block with POLL_MAX set to 8 and keeps the default address map and argument count. That limit makes it possible to sweep the responder's answer delay over every value from zero zero-reads up to the full limit and one past it. Each delay is combined with all five named response codes and two unnamed non-zero words. Every one of those runs checks the exact bus order, the poll count, the completion latency and the classification. The last-allowed-poll and first-timeout cases sit side by side in this sweep.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CLR,
    S_WARG,
    S_WMSG,
    S_PRD,
    S_PCHK,
    S_RARG,
    S_RTAIL,
    S_DONE
  } seq_state_e;

  localparam logic [2:0] KIND_OK      = 3'd0;
  localparam logic [2:0] KIND_FAILED  = 3'd1;
  localparam logic [2:0] KIND_UNKNOWN = 3'd2;
  localparam logic [2:0] KIND_PREREQ  = 3'd3;
  localparam logic [2:0] KIND_BUSY    = 3'd4;
  localparam logic [2:0] KIND_OTHER   = 3'd5;
  localparam logic [2:0] KIND_TIMEOUT = 3'd6;

  localparam logic [7:0] RC_OK      = 8'h01;
  localparam logic [7:0] RC_FAILED  = 8'hFF;
  localparam logic [7:0] RC_UNKNOWN = 8'hFE;
  localparam logic [7:0] RC_PREREQ  = 8'hFD;
  localparam logic [7:0] RC_BUSY    = 8'hFC;

endpackage

// File: rtl/mbox_poll_ctr.sv
module mbox_poll_ctr #(
  parameter int POLL_MAX = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic hit_o
);
  localparam int CW = $clog2(POLL_MAX + 1);
  localparam logic [CW-1:0] LIMIT = CW'(POLL_MAX);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    cnt_d  = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hit_o = (cnt_q == LIMIT);

  // R6: the count never passes the limit
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  // R6: no poll is issued once the limit has been reached
  a_r6_no_poll_past_limit: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |-> (cnt_q < LIMIT));

endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int N_ARGS   = 6,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int MSG_ADDR = 0,
  parameter int ARG_BASE = 1,
  parameter int RSP_ADDR = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [DATA_W-1:0]        cmd_i,
  input  logic [N_ARGS*DATA_W-1:0] args_i,
  input  logic                     poll_hit_i,
  input  logic [DATA_W-1:0]        rdata_i,
  output logic                     bus_req_o,
  output logic                     bus_we_o,
  output logic [ADDR_W-1:0]        bus_addr_o,
  output logic [DATA_W-1:0]        bus_wdata_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     accept_o,
  output logic                     poll_inc_o,
  output logic                     stat_ld_o,
  output logic                     tmo_ld_o,
  output logic                     cap_vld_o,
  output logic [$clog2(N_ARGS)-1:0] cap_idx_o
);
  localparam int IDX_W = $clog2(N_ARGS);
  localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(N_ARGS - 1);
  localparam logic [ADDR_W-1:0] A_MSG    = ADDR_W'(MSG_ADDR);
  localparam logic [ADDR_W-1:0] A_RSP    = ADDR_W'(RSP_ADDR);
  localparam logic [ADDR_W-1:0] A_ARG0   = ADDR_W'(ARG_BASE);
  localparam logic [ADDR_W-1:0] A_ARGL   = ADDR_W'(ARG_BASE + N_ARGS - 1);

  seq_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] cmd_q;
  logic [DATA_W-1:0] arg_q [N_ARGS];
  logic              cap_vld_q;
  logic [IDX_W-1:0]  cap_idx_q;
  logic              rsp_nz;

  assign rsp_nz = (rdata_i != '0);

  // next-state and bus drive
  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    accept_o    = 1'b0;
    poll_inc_o  = 1'b0;
    stat_ld_o   = 1'b0;
    tmo_ld_o    = 1'b0;
    bus_req_o   = 1'b0;
    bus_we_o    = 1'b0;
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          state_d  = S_CLR;
        end
      end
      S_CLR: begin
        bus_req_o  = 1'b1;
        bus_we_o   = 1'b1;
        bus_addr_o = A_RSP;
        idx_d      = '0;
        state_d    = S_WARG;
      end
      S_WARG: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = A_ARG0 + ADDR_W'(idx_q);
        bus_wdata_o = arg_q[idx_q];
        if (idx_q == IDX_LAST) state_d = S_WMSG;
        else                   idx_d   = idx_q + 1'b1;
      end
      S_WMSG: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = A_MSG;
        bus_wdata_o = cmd_q;
        state_d     = S_PRD;
      end
      S_PRD: begin
        bus_req_o  = 1'b1;
        bus_addr_o = A_RSP;
        poll_inc_o = 1'b1;
        state_d    = S_PCHK;
      end
      S_PCHK: begin
        if (rsp_nz) begin
          stat_ld_o = 1'b1;
          idx_d     = '0;
          state_d   = S_RARG;
        end else if (poll_hit_i) begin
          tmo_ld_o = 1'b1;
          state_d  = S_DONE;
        end else begin
          state_d = S_PRD;
        end
      end
      S_RARG: begin
        bus_req_o  = 1'b1;
        bus_addr_o = A_ARG0 + ADDR_W'(idx_q);
        if (idx_q == IDX_LAST) state_d = S_RTAIL;
        else                   idx_d   = idx_q + 1'b1;
      end
      S_RTAIL: state_d = S_DONE;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      idx_q     <= '0;
      cap_vld_q <= 1'b0;
      cap_idx_q <= '0;
    end else begin
      state_q   <= state_d;
      idx_q     <= idx_d;
      cap_vld_q <= (state_q == S_RARG);
      cap_idx_q <= idx_q;
    end
  end

  // request capture, clock-enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      for (int i = 0; i < N_ARGS; i++) arg_q[i] <= '0;
    end else if (accept_o) begin
      cmd_q <= cmd_i;
      for (int i = 0; i < N_ARGS; i++) arg_q[i] <= args_i[i*DATA_W +: DATA_W];
    end
  end

  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = (state_q == S_DONE);
  assign cap_vld_o = cap_vld_q;
  assign cap_idx_o = cap_idx_q;

  // R2: a transaction opens with the response clear
  a_r2_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (bus_req_o && bus_we_o && bus_addr_o == A_RSP && bus_wdata_o == '0));
  // R3: each argument write past the first follows the previous index
  a_r3_arg_order: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && bus_we_o && bus_addr_o > A_ARG0 && bus_addr_o <= A_ARGL)
      |-> ($past(bus_req_o && bus_we_o) && $past(bus_addr_o) == bus_addr_o - 1'b1));
  // R4: the command write comes right after the last argument write
  a_r4_msg_after_args: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && bus_we_o && bus_addr_o == A_MSG)
      |-> $past(bus_req_o && bus_we_o && bus_addr_o == A_ARGL));
  // R9: busy drops right after done
  a_r9_done_release: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
  // R9: a start while busy leaves the captured command alone
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(cmd_q));

endmodule

// File: rtl/mbox_result.sv
module mbox_result
  import mbox_pkg::*;
#(
  parameter int N_ARGS = 6,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      accept_i,
  input  logic                      stat_ld_i,
  input  logic                      tmo_ld_i,
  input  logic                      cap_vld_i,
  input  logic [$clog2(N_ARGS)-1:0] cap_idx_i,
  input  logic [DATA_W-1:0]         rdata_i,
  output logic [N_ARGS*DATA_W-1:0]  args_o,
  output logic [DATA_W-1:0]         status_o,
  output logic [2:0]                kind_o,
  output logic                      err_o,
  output logic                      timeout_o
);
  localparam int IDX_W = $clog2(N_ARGS);

  logic [DATA_W-1:0] arg_q [N_ARGS];
  logic [DATA_W-1:0] status_q, status_d;
  logic [2:0]        kind_q, kind_d, kind_rsp;
  logic              tmo_q, tmo_d;
  logic              st_en;

  // classification of the response word
  always_comb begin
    if (rdata_i == DATA_W'(RC_OK))           kind_rsp = KIND_OK;
    else if (rdata_i == DATA_W'(RC_FAILED))  kind_rsp = KIND_FAILED;
    else if (rdata_i == DATA_W'(RC_UNKNOWN)) kind_rsp = KIND_UNKNOWN;
    else if (rdata_i == DATA_W'(RC_PREREQ))  kind_rsp = KIND_PREREQ;
    else if (rdata_i == DATA_W'(RC_BUSY))    kind_rsp = KIND_BUSY;
    else                                     kind_rsp = KIND_OTHER;
  end

  always_comb begin
    st_en    = accept_i | stat_ld_i | tmo_ld_i;
    status_d = status_q;
    kind_d   = kind_q;
    tmo_d    = tmo_q;
    if (accept_i) begin
      status_d = '0;
      kind_d   = KIND_OK;
      tmo_d    = 1'b0;
    end else if (stat_ld_i) begin
      status_d = rdata_i;
      kind_d   = kind_rsp;
      tmo_d    = 1'b0;
    end else if (tmo_ld_i) begin
      status_d = '0;
      kind_d   = KIND_TIMEOUT;
      tmo_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      kind_q   <= KIND_OK;
      tmo_q    <= 1'b0;
    end else if (st_en) begin
      status_q <= status_d;
      kind_q   <= kind_d;
      tmo_q    <= tmo_d;
    end
  end

  // one capture register per argument slot
  for (genvar g = 0; g < N_ARGS; g++) begin : g_slot
    logic slot_en;
    assign slot_en = accept_i | (cap_vld_i && cap_idx_i == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       arg_q[g] <= '0;
      else if (slot_en) arg_q[g] <= accept_i ? '0 : rdata_i;
    end
    assign args_o[g*DATA_W +: DATA_W] = arg_q[g];
  end

  assign status_o  = status_q;
  assign kind_o    = kind_q;
  assign err_o     = (kind_q != KIND_OK);
  assign timeout_o = tmo_q;

  // R7: captures only ever target an existing slot
  a_r7_cap_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cap_vld_i |-> (cap_idx_i <= IDX_W'(N_ARGS - 1)));
  // R6: a timeout always reports a zero status
  a_r6_timeout_zero: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (status_o == '0 && err_o));
  // R7: no capture and status load in the same cycle
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_vld_i && (stat_ld_i || tmo_ld_i)));

endmodule

// File: rtl/mbox_seq.sv
module mbox_seq #(
  parameter int N_ARGS   = 6,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int MSG_ADDR = 0,
  parameter int ARG_BASE = 1,
  parameter int RSP_ADDR = 7,
  parameter int POLL_MAX = 1024
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [DATA_W-1:0]        cmd_i,
  input  logic [N_ARGS*DATA_W-1:0] args_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [N_ARGS*DATA_W-1:0] args_o,
  output logic [DATA_W-1:0]        status_o,
  output logic [2:0]               kind_o,
  output logic                     err_o,
  output logic                     timeout_o,
  output logic                     bus_req_o,
  output logic                     bus_we_o,
  output logic [ADDR_W-1:0]        bus_addr_o,
  output logic [DATA_W-1:0]        bus_wdata_o,
  input  logic [DATA_W-1:0]        bus_rdata_i
);
  localparam int IDX_W = $clog2(N_ARGS);

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             accept, poll_inc, poll_hit, stat_ld, tmo_ld, cap_vld;
  logic [IDX_W-1:0] cap_idx;

  mbox_ctrl #(
    .N_ARGS(N_ARGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .MSG_ADDR(MSG_ADDR), .ARG_BASE(ARG_BASE), .RSP_ADDR(RSP_ADDR)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (start_i),
    .cmd_i       (cmd_i),
    .args_i      (args_i),
    .poll_hit_i  (poll_hit),
    .rdata_i     (bus_rdata_i),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .accept_o    (accept),
    .poll_inc_o  (poll_inc),
    .stat_ld_o   (stat_ld),
    .tmo_ld_o    (tmo_ld),
    .cap_vld_o   (cap_vld),
    .cap_idx_o   (cap_idx)
  );

  mbox_poll_ctr #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr_i (accept),
    .inc_i (poll_inc),
    .hit_o (poll_hit)
  );

  mbox_result #(.N_ARGS(N_ARGS), .DATA_W(DATA_W)) u_result (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .accept_i  (accept),
    .stat_ld_i (stat_ld),
    .tmo_ld_i  (tmo_ld),
    .cap_vld_i (cap_vld),
    .cap_idx_i (cap_idx),
    .rdata_i   (bus_rdata_i),
    .args_o    (args_o),
    .status_o  (status_o),
    .kind_o    (kind_o),
    .err_o     (err_o),
    .timeout_o (timeout_o)
  );

  // R8: a clean completion carries the success word
  a_r8_ok_status: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_o && !err_o) |-> (status_o == DATA_W'(1)));
  // R1: no bus traffic while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy_o |-> !bus_req_o);
  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |=> !done_o);

endmodule

// File: tb/test_mbox_seq.sv
module test_mbox_seq;
  localparam int N    = 6;
  localparam int DW   = 32;
  localparam int AW   = 4;
  localparam int A_MSG = 0;
  localparam int A_ARG = 1;
  localparam int A_RSP = 7;
  localparam int PMAX = 8;

  logic            clk, rst_n, start_i;
  logic [DW-1:0]   cmd_i;
  logic [N*DW-1:0] args_i;
  logic            busy_o, done_o, err_o, timeout_o;
  logic [N*DW-1:0] args_o;
  logic [DW-1:0]   status_o;
  logic [2:0]      kind_o;
  logic            bus_req, bus_we;
  logic [AW-1:0]   bus_addr;
  logic [DW-1:0]   bus_wdata, bus_rdata;

  mbox_seq #(.N_ARGS(N), .DATA_W(DW), .ADDR_W(AW), .MSG_ADDR(A_MSG),
             .ARG_BASE(A_ARG), .RSP_ADDR(A_RSP), .POLL_MAX(PMAX)) i_mbox_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i), .args_i(args_i),
    .busy_o(busy_o), .done_o(done_o), .args_o(args_o), .status_o(status_o),
    .kind_o(kind_o), .err_o(err_o), .timeout_o(timeout_o),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;

  // responder configuration and expectations, driven by the stimulus
  logic          tx_new;
  int            cfg_delay;
  logic [DW-1:0] cfg_status;
  logic [DW-1:0] exp_cmd;
  logic [DW-1:0] exp_arg [N];

  // responder model and bus monitor
  logic [DW-1:0] mem [8];
  logic          armed, bad;
  int            pcnt, step, arg_rd, rsp_rd;

  always @(posedge clk) begin
    if (tx_new) begin
      armed <= 1'b0; pcnt <= 0; step <= 0; arg_rd <= 0; rsp_rd <= 0; bad <= 1'b0;
    end else if (bus_req) begin
      if (bus_we) begin
        mem[bus_addr[2:0]] <= bus_wdata;
        if (step == 0) begin
          if (bus_addr != AW'(A_RSP) || bus_wdata != '0) bad <= 1'b1;
        end else if (step <= N) begin
          if (bus_addr != AW'(A_ARG + step - 1) || bus_wdata != exp_arg[step-1]) bad <= 1'b1;
        end else if (step == N + 1) begin
          if (bus_addr != AW'(A_MSG) || bus_wdata != exp_cmd) bad <= 1'b1;
          armed <= 1'b1;
          for (int i = 0; i < N; i++) mem[A_ARG+i] <= ~mem[A_ARG+i] ^ bus_wdata;
        end else begin
          bad <= 1'b1;
        end
        step <= step + 1;
      end else begin
        if (step != N + 2) bad <= 1'b1;
        if (bus_addr == AW'(A_RSP)) begin
          bus_rdata <= (armed && pcnt >= cfg_delay) ? cfg_status : '0;
          pcnt   <= pcnt + 1;
          rsp_rd <= rsp_rd + 1;
          if (arg_rd != 0) bad <= 1'b1;
        end else begin
          if (bus_addr != AW'(A_ARG + arg_rd)) bad <= 1'b1;
          bus_rdata <= mem[bus_addr[2:0]];
          arg_rd <= arg_rd + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_kind(input logic [DW-1:0] s);
    case (s)
      32'h01:  return 3'd0;
      32'hFF:  return 3'd1;
      32'hFE:  return 3'd2;
      32'hFD:  return 3'd3;
      32'hFC:  return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

  task automatic run_txn(input logic [DW-1:0] cmd, input int seed, input int d,
                         input logic [DW-1:0] st, input bit inject);
    int cnt;
    bit tmo;
    int exp_lat;
    logic [N*DW-1:0] exp_out, held;
    tmo = (d >= PMAX);
    @(negedge clk);
    tx_new = 1'b1; cfg_delay = d; cfg_status = st; exp_cmd = cmd;
    for (int i = 0; i < N; i++) exp_arg[i] = DW'(seed) * 32'h9E3779B1 + DW'(i) * 32'h01030507;
    @(negedge clk);
    tx_new = 1'b0;
    start_i = 1'b1; cmd_i = cmd;
    for (int i = 0; i < N; i++) args_i[i*DW +: DW] = exp_arg[i];
    @(negedge clk);
    start_i = 1'b0;
    cnt = 1;
    chk(busy_o == 1'b1, "R9 busy after accept", 64'(busy_o), 64'd1);
    while (!done_o && cnt < 200) begin
      if (inject && (cnt == 2 || cnt == 3 || cnt == 12)) begin
        start_i = 1'b1; cmd_i = cmd ^ 32'hDEAD0000; args_i = ~args_i;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    start_i = 1'b0;
    exp_lat = tmo ? (9 + 2 * PMAX) : (16 + 2 * (d + 1));
    chk(cnt == exp_lat, "R7 R5 done latency", 64'(cnt), 64'(exp_lat));
    chk(done_o == 1'b1 && busy_o == 1'b1, "R9 done with busy", {62'd0, done_o, busy_o}, 64'd3);
    chk(bad == 1'b0, "R2 R3 R4 bus access order", 64'(bad), 64'd0);
    chk(rsp_rd == (tmo ? PMAX : d + 1), "R5 response poll count", 64'(rsp_rd), 64'(tmo ? PMAX : d + 1));
    chk(arg_rd == (tmo ? 0 : N), "R7 R6 argument read count", 64'(arg_rd), 64'(tmo ? 0 : N));
    for (int i = 0; i < N; i++) exp_out[i*DW +: DW] = tmo ? '0 : (~exp_arg[i] ^ cmd);
    chk(args_o == exp_out, "R7 returned arguments", args_o[63:0], exp_out[63:0]);
    if (tmo) begin
      chk(timeout_o && err_o && status_o == '0 && kind_o == 3'd6, "R6 timeout report",
          {27'd0, timeout_o, err_o, kind_o, status_o}, {27'd0, 1'b1, 1'b1, 3'd6, 32'd0});
    end else begin
      chk(status_o == st, "R8 status word", 64'(status_o), 64'(st));
      chk(kind_o == exp_kind(st), "R8 classification", 64'(kind_o), 64'(exp_kind(st)));
      chk(err_o == (st != 32'h1) && !timeout_o, "R8 error flag", {62'd0, err_o, timeout_o},
          {62'd0, (st != 32'h1), 1'b0});
    end
    held = args_o;
    @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R9 done pulse and release", {62'd0, done_o, busy_o}, 64'd0);
    repeat (3) @(negedge clk);
    chk(args_o == held && bus_req == 1'b0, "R9 results held while idle", args_o[63:0], held[63:0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] codes [7];
    codes[0] = 32'h01; codes[1] = 32'hFF; codes[2] = 32'hFE; codes[3] = 32'hFD;
    codes[4] = 32'hFC; codes[5] = 32'h37; codes[6] = 32'h8000_0001;
    rst_n = 1'b0; start_i = 1'b0; cmd_i = '0; args_i = '0; tx_new = 1'b1;
    cfg_delay = 0; cfg_status = '0; exp_cmd = '0; bus_rdata = '0;
    for (int i = 0; i < N; i++) exp_arg[i] = '0;
    for (int i = 0; i < 8; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0 && bus_req == 1'b0, "R1 state in reset",
        {61'd0, busy_o, done_o, bus_req}, 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0 && bus_req == 1'b0, "R1 idle after reset",
        {61'd0, busy_o, done_o, bus_req}, 64'd0);
    for (int c = 0; c < 7; c++) begin
      for (int d = 0; d <= PMAX; d++) begin
        run_txn(32'h40 + DW'(c * 16 + d), c * 31 + d + 1, d, codes[c], ((c + d) % 2) == 1);
      end
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule